// File: doc/BRIEF.md
# Register-Triggered Block Copy Engine

This block is a memory-to-memory copy engine that a processor programs through a byte-wide I/O port bus. Software sets up a source pointer, a destination pointer and a byte count in eight byte-sized port registers. It then writes a control byte with the start bit set. The engine moves the bytes one at a time over a simple byte memory master interface. Each byte takes one read cycle at the source, followed by one write cycle at the destination.

Both pointers step by one after every byte. A direction bit in the control byte selects whether they count up or down. Only the lower 16 bits of each pointer take part in the stepping. The upper source nibble and the upper destination byte select a fixed 64 KiB window for the whole transfer. When the last byte has been written, the stepped pointers stay in their registers, and the length and control registers read zero.

Software can poll the busy bit in the control register to find out when the copy has finished. The memory interface has a fixed read latency of one cycle. Read data that arrives in the cycle after `memRdEn` is passed straight through to `memWrData`.

Top module: `blkCopyDma`

## Requirements
- R1: After reset every port register at 0x40 to 0x48 reads 0x00, and neither memory strobe is asserted.
- R2: The source address on `memRdAddr` is {port 0x42 bits 3..0, port 0x41, port 0x40}. Bits 7..4 of port 0x42 are not stored and read as zero.
- R3: The destination address on `memWrAddr` is {port 0x43, port 0x45, port 0x44}.
- R4: Writing port 0x48 with bit 7 set while the engine is idle and the length is nonzero starts a transfer. In the next cycle `memRdEn` is high at the source pointer. In the cycle after that, `memWrEn` is high at the destination pointer and carries the returned read data. The two strobes are never high together.
- R5: The 16-bit length (low byte at port 0x46, high byte at port 0x47) gives exactly how many read/write byte pairs the transfer makes.
- R6: When control bit 0 is 1, both pointers decrement after each byte; when it is 0, they increment. Stepping changes only the lower 16 bits, wraps within them, and leaves ports 0x42 and 0x43 untouched.
- R7: After the last byte is written, ports 0x46, 0x47 and 0x48 read 0x00.
- R8: After the transfer, ports 0x40, 0x41, 0x44 and 0x45 hold the pointers advanced by the original length.
- R9: A start with a length of zero makes no memory access, and port 0x48 reads 0x00 in the next cycle.
- R10: Port 0x48 reads {busy, 6'b0, direction}. Busy is 1 from the cycle after a start until the last write has completed. A write to port 0x48 with bit 7 clear only records the direction.
- R11: Port writes to 0x40 to 0x48 while a transfer is in progress have no effect.
- R12: `ioRdData` returns the addressed register in the same cycle, and reads 0x00 for port addresses outside 0x40 to 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Port write strobe |
| ioAddr | input | 8 | Port address for both reads and writes |
| ioWrData | input | 8 | Port write data |
| ioRdData | output | 8 | Readback of the addressed port |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 20 | Memory read address |
| memRdData | input | 8 | Read data, valid in the cycle after memRdEn |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 24 | Memory write address |
| memWrData | output | 8 | Memory write data |

## Verification
The assertions assume that memory read data always arrives exactly one cycle after the read strobe. They also assume that software does not reprogram the engine between two transfers with fewer than one idle cycle in between. The bench memory model keeps to the first assumption: it registers its read data on the edge that ends the read cycle. The bench's stimulus keeps to the second, because it only starts a new transfer after polling has shown the busy bit clear. The direction-step check also assumes that the direction bit stays constant during a transfer. The stimulus tests this assumption directly by writing the control port while the engine is busy.

// File: rtl/blkCopyDmaPkg.sv
package blkCopyDmaPkg;
  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic rdPhase;    // read cycle of a byte pair
    logic wrPhase;    // write cycle of a byte pair, pointers step on its edge
    logic regWrOk;    // port writes may land (engine idle)
    logic clearCtrl;  // transfer finished: control byte returns to zero
    logic busy;       // transfer in progress
  } dmaStrobes_t;
endpackage

// File: rtl/blkCopyDmaCtrl.sv
module blkCopyDmaCtrl
  import blkCopyDmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic        startBit,
  input  logic        lenZero,
  input  logic        lenOne,
  output dmaStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seqState_t;
  seqState_t stateQ, stateD;
  logic startGo;

  assign startGo = ctrlWr && startBit && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (startGo && !lenZero) stateD = ST_RD;
      ST_RD:   stateD = ST_WR;
      ST_WR:   stateD = lenOne ? ST_IDLE : ST_RD;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.rdPhase   = (stateQ == ST_RD);
    strb.wrPhase   = (stateQ == ST_WR);
    strb.busy      = (stateQ != ST_IDLE);
    strb.regWrOk   = (stateQ == ST_IDLE);
    strb.clearCtrl = ((stateQ == ST_WR) && lenOne) || (startGo && lenZero);
  end
endmodule

// File: rtl/blkCopyDmaRegs.sv
module blkCopyDmaRegs
  import blkCopyDmaPkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          SRC_HI_W  = 4,
  parameter logic [7:0]  PORT_BASE = 8'h40
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dmaStrobes_t                       strb,
  input  logic                              ioWrEn,
  input  logic [7:0]                        ioAddr,
  input  logic [DATA_W-1:0]                 ioWrData,
  output logic [DATA_W-1:0]                 ioRdData,
  output logic                              ctrlWr,
  output logic                              startBit,
  output logic                              lenZero,
  output logic                              lenOne,
  output logic                              dirQ,
  output logic                              memRdEn,
  output logic [2*DATA_W+SRC_HI_W-1:0]      memRdAddr,
  input  logic [DATA_W-1:0]                 memRdData,
  output logic                              memWrEn,
  output logic [3*DATA_W-1:0]               memWrAddr,
  output logic [DATA_W-1:0]                 memWrData
);
  localparam int LO_W = 2 * DATA_W;
  localparam int NUM_PORTS = 9;
  localparam logic [7:0] P_SRC0 = PORT_BASE;
  localparam logic [7:0] P_SRC1 = PORT_BASE + 8'd1;
  localparam logic [7:0] P_SRC2 = PORT_BASE + 8'd2;
  localparam logic [7:0] P_DST2 = PORT_BASE + 8'd3;
  localparam logic [7:0] P_DST0 = PORT_BASE + 8'd4;
  localparam logic [7:0] P_DST1 = PORT_BASE + 8'd5;
  localparam logic [7:0] P_LEN0 = PORT_BASE + 8'd6;
  localparam logic [7:0] P_LEN1 = PORT_BASE + 8'd7;
  localparam logic [7:0] P_CTRL = PORT_BASE + 8'd8;

  logic [LO_W-1:0]     srcLo, dstLo, lenQ, stepVal;
  logic [SRC_HI_W-1:0] srcHi;
  logic [DATA_W-1:0]   dstHi;
  logic [NUM_PORTS-1:0] portHit;
  logic [DATA_W-1:0]   portVal [NUM_PORTS];

  assign ctrlWr   = ioWrEn && (ioAddr == P_CTRL);
  assign startBit = ioWrData[DATA_W-1];
  assign lenZero  = (lenQ == '0);
  assign lenOne   = (lenQ == LO_W'(1));
  assign stepVal  = dirQ ? '1 : LO_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcLo <= '0; srcHi <= '0; dstLo <= '0; dstHi <= '0;
      lenQ  <= '0; dirQ  <= 1'b0;
    end else begin
      if (ioWrEn && strb.regWrOk) begin
        case (ioAddr)
          P_SRC0: srcLo[DATA_W-1:0]    <= ioWrData;
          P_SRC1: srcLo[LO_W-1:DATA_W] <= ioWrData;
          P_SRC2: srcHi                <= ioWrData[SRC_HI_W-1:0];
          P_DST2: dstHi                <= ioWrData;
          P_DST0: dstLo[DATA_W-1:0]    <= ioWrData;
          P_DST1: dstLo[LO_W-1:DATA_W] <= ioWrData;
          P_LEN0: lenQ[DATA_W-1:0]     <= ioWrData;
          P_LEN1: lenQ[LO_W-1:DATA_W]  <= ioWrData;
          P_CTRL: dirQ <= strb.clearCtrl ? 1'b0 : ioWrData[0];
          default: ;
        endcase
      end
      if (strb.wrPhase) begin
        srcLo <= srcLo + stepVal;
        dstLo <= dstLo + stepVal;
        lenQ  <= lenQ - LO_W'(1);
        if (strb.clearCtrl) dirQ <= 1'b0;
      end
    end
  end

  // readback table, one entry per port offset
  always_comb begin
    portVal[0] = srcLo[DATA_W-1:0];
    portVal[1] = srcLo[LO_W-1:DATA_W];
    portVal[2] = {{(DATA_W-SRC_HI_W){1'b0}}, srcHi};
    portVal[3] = dstHi;
    portVal[4] = dstLo[DATA_W-1:0];
    portVal[5] = dstLo[LO_W-1:DATA_W];
    portVal[6] = lenQ[DATA_W-1:0];
    portVal[7] = lenQ[LO_W-1:DATA_W];
    portVal[8] = {strb.busy, {(DATA_W-2){1'b0}}, dirQ};
  end

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_hit
    assign portHit[gi] = (ioAddr == PORT_BASE + 8'(gi));
  end

  always_comb begin
    ioRdData = '0;
    for (int k = 0; k < NUM_PORTS; k++)
      if (portHit[k]) ioRdData = portVal[k];
  end

  assign memRdEn   = strb.rdPhase;
  assign memRdAddr = {srcHi, srcLo};
  assign memWrEn   = strb.wrPhase;
  assign memWrAddr = {dstHi, dstLo};
  assign memWrData = memRdData;
endmodule

// File: rtl/blkCopyDma.sv
module blkCopyDma
  import blkCopyDmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWrEn,
  input  logic [7:0]  ioAddr,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  output logic        memRdEn,
  output logic [19:0] memRdAddr,
  input  logic [7:0]  memRdData,
  output logic        memWrEn,
  output logic [23:0] memWrAddr,
  output logic [7:0]  memWrData
);
  dmaStrobes_t strb;
  logic ctrlWr, startBit, lenZero, lenOne, dirQ, busy;

  assign busy = strb.busy;

  blkCopyDmaCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .startBit(startBit),
    .lenZero(lenZero), .lenOne(lenOne), .strb(strb)
  );

  blkCopyDmaRegs #(.DATA_W(8), .SRC_HI_W(4), .PORT_BASE(8'h40)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .ctrlWr(ctrlWr), .startBit(startBit), .lenZero(lenZero), .lenOne(lenOne),
    .dirQ(dirQ),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/blkCopyDmaChk.sv
module blkCopyDmaChk (
  input logic        clk,
  input logic        rstN,
  input logic        ioWrEn,
  input logic [7:0]  ioAddr,
  input logic [7:0]  ioWrData,
  input logic        memRdEn,
  input logic [19:0] memRdAddr,
  input logic        memWrEn,
  input logic        busy,
  input logic        dirQ,
  input logic        lenZero
);
  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> memWrEn);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R10
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == 8'h48 && ioWrData[7] && !busy && lenZero) |=> (!memRdEn && !busy));

  // R6
  step_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn, 2)) |->
      (memRdAddr[15:0] == (dirQ ? 16'($past(memRdAddr[15:0], 2) - 16'd1)
                                : 16'($past(memRdAddr[15:0], 2) + 16'd1))));

  // R2
  src_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memRdAddr[19:16]));
endmodule

bind blkCopyDma blkCopyDmaChk i_chk (.*);

// File: tb/test_blkCopyDma.sv
module test_blkCopyDma;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWrEn = 1'b0;
  logic [7:0] ioAddr = 8'h00, ioWrData = 8'h00;
  logic [7:0] ioRdData;
  logic memRdEn, memWrEn;
  logic [19:0] memRdAddr;
  logic [23:0] memWrAddr;
  logic [7:0] memRdData = 8'h00, memWrData;

  always #2 clk = ~clk;

  blkCopyDma i_blkCopyDma (.*);

  int nChecks = 0, nFails = 0, rdCount = 0, wrCount = 0;
  logic [7:0] mem [int];

  // reference model state
  int mPhase = 0;
  logic [15:0] mSrcLo = 0, mDstLo = 0, mLen = 0;
  logic [3:0]  mSrcHi = 0;
  logic [7:0]  mDstHi = 0, mData = 0;
  logic        mDir = 0;

  function automatic logic [7:0] memVal(int a);
    if (mem.exists(a)) return mem[a];
    return 8'(a ^ (a >> 8)) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mRead(logic [7:0] a);
    case (a)
      8'h40: return mSrcLo[7:0];
      8'h41: return mSrcLo[15:8];
      8'h42: return {4'h0, mSrcHi};
      8'h43: return mDstHi;
      8'h44: return mDstLo[7:0];
      8'h45: return mDstLo[15:8];
      8'h46: return mLen[7:0];
      8'h47: return mLen[15:8];
      8'h48: return {(mPhase != 0), 6'b0, mDir};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory environment plus reference model, advanced on every edge
  always @(posedge clk) begin
    if (memRdEn) begin memRdData <= memVal(int'(memRdAddr)); rdCount++; end
    if (memWrEn) begin mem[int'(memWrAddr)] = memWrData; wrCount++; end
    if (!rstN) begin
      mPhase = 0; mSrcLo = 0; mDstLo = 0; mLen = 0; mSrcHi = 0; mDstHi = 0; mDir = 0;
    end else begin
      int busyNow;
      busyNow = mPhase;
      if (mPhase == 2) begin
        mSrcLo = mDir ? mSrcLo - 16'd1 : mSrcLo + 16'd1;
        mDstLo = mDir ? mDstLo - 16'd1 : mDstLo + 16'd1;
        mLen = mLen - 16'd1;
        if (mLen == 0) begin mPhase = 0; mDir = 0; end else mPhase = 1;
      end else if (mPhase == 1) begin
        mData = memVal(int'({mSrcHi, mSrcLo}));
        mPhase = 2;
      end
      if (ioWrEn && busyNow == 0) begin
        case (ioAddr)
          8'h40: mSrcLo[7:0] = ioWrData;
          8'h41: mSrcLo[15:8] = ioWrData;
          8'h42: mSrcHi = ioWrData[3:0];
          8'h43: mDstHi = ioWrData;
          8'h44: mDstLo[7:0] = ioWrData;
          8'h45: mDstLo[15:8] = ioWrData;
          8'h46: mLen[7:0] = ioWrData;
          8'h47: mLen[15:8] = ioWrData;
          8'h48: begin
            if (ioWrData[7] && mLen == 0) mDir = 0;
            else begin mDir = ioWrData[0]; if (ioWrData[7]) mPhase = 1; end
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      check("R4 rd strobe", memRdEn, mPhase == 1);
      if (mPhase == 1) check("R2 rd addr", memRdAddr, {mSrcHi, mSrcLo});
      check("R5 wr strobe", memWrEn, mPhase == 2);
      if (mPhase == 2) begin
        check("R3 wr addr", memWrAddr, {mDstHi, mDstLo});
        check("R4 wr data", memWrData, mData);
      end
      check("R12 readback", ioRdData, mRead(ioAddr));
    end
  end

  task automatic wrPort(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic rdPort(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a;
    #1 d = ioRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rdPort(8'h48, v);
      if (!v[7]) break;
    end
  endtask

  task automatic expPort(string tag, logic [7:0] a, logic [7:0] e);
    logic [7:0] v;
    rdPort(a, v);
    check(tag, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int rc, wc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 8'h40; a <= 8'h48; a++) expPort("R1 reset reg", 8'(a), 8'h00);
    check("R1 no access", rdCount + wrCount, 0);
    // R12 unmapped ports
    wrPort(8'h49, 8'hFF);
    expPort("R12 unmapped 49", 8'h49, 8'h00);
    expPort("R12 unmapped 3F", 8'h3F, 8'h00);

    // ascending copy, 3 bytes
    wrPort(8'h40, 8'hFE); wrPort(8'h41, 8'h12); wrPort(8'h42, 8'hF3);
    wrPort(8'h43, 8'hAB); wrPort(8'h44, 8'h00); wrPort(8'h45, 8'h70);
    wrPort(8'h46, 8'h03); wrPort(8'h47, 8'h00);
    expPort("R2 hi nibble", 8'h42, 8'h03);
    wrPort(8'h48, 8'h80);
    expPort("R10 busy", 8'h48, 8'h80);
    wrPort(8'h46, 8'h55);  // R11 ignored while busy
    wrPort(8'h40, 8'h00);
    waitIdle();
    expPort("R7 len lo", 8'h46, 8'h00);
    expPort("R7 len hi", 8'h47, 8'h00);
    expPort("R7 ctrl", 8'h48, 8'h00);
    expPort("R8 R11 src lo", 8'h40, 8'h01);
    expPort("R8 src mid", 8'h41, 8'h13);
    expPort("R8 dst lo", 8'h44, 8'h03);
    expPort("R8 dst mid", 8'h45, 8'h70);
    expPort("R6 src hi kept", 8'h42, 8'h03);
    expPort("R6 dst hi kept", 8'h43, 8'hAB);
    for (int i = 0; i < 3; i++)
      check("R5 copied byte", mem[32'hAB7000 + i], memVal(32'h312FE + i));
    check("R5 pair count", wrCount, 3);

    // descending copy across the 16-bit wrap
    wrPort(8'h40, 8'h01); wrPort(8'h41, 8'h00); wrPort(8'h42, 8'h00);
    wrPort(8'h43, 8'h01); wrPort(8'h44, 8'h00); wrPort(8'h45, 8'h00);
    wrPort(8'h46, 8'h03);
    wrPort(8'h48, 8'h81);
    expPort("R10 busy dir", 8'h48, 8'h81);
    wrPort(8'h48, 8'h00);  // R11 control ignored while busy
    waitIdle();
    expPort("R6 src lo wrap", 8'h40, 8'hFE);
    expPort("R6 src mid wrap", 8'h41, 8'hFF);
    expPort("R6 dst lo wrap", 8'h44, 8'hFD);
    expPort("R6 dst hi kept", 8'h43, 8'h01);
    check("R6 byte0", mem[32'h010000], memVal(32'h00001));
    check("R6 byte1", mem[32'h01FFFF], memVal(32'h00000));
    check("R6 byte2", mem[32'h01FFFE], memVal(32'h0FFFF));

    // zero length start
    rc = rdCount; wc = wrCount;
    wrPort(8'h48, 8'h81);
    expPort("R9 ctrl zero", 8'h48, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 no access", (rdCount - rc) + (wrCount - wc), 0);

    // direction only, no start
    wrPort(8'h46, 8'h01);
    rc = rdCount;
    wrPort(8'h48, 8'h01);
    expPort("R10 dir only", 8'h48, 8'h01);
    repeat (3) @(negedge clk);
    check("R10 no start", rdCount - rc, 0);

    // long ascending copy of 257 bytes
    wrPort(8'h40, 8'h00); wrPort(8'h41, 8'h00); wrPort(8'h42, 8'h02);
    wrPort(8'h43, 8'h05); wrPort(8'h44, 8'h00); wrPort(8'h45, 8'h80);
    wrPort(8'h46, 8'h01); wrPort(8'h47, 8'h01);
    wc = wrCount;
    wrPort(8'h48, 8'h80);
    waitIdle();
    check("R5 long count", wrCount - wc, 257);
    expPort("R8 long src lo", 8'h40, 8'h01);
    expPort("R8 long src mid", 8'h41, 8'h01);
    expPort("R8 long dst mid", 8'h45, 8'h81);
    expPort("R7 long len hi", 8'h47, 8'h00);
    check("R5 long last", mem[32'h058100], memVal(32'h20100));

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule